// File: doc/BRIEF.md
# ADC Conversion Abort Controller

This block watches the register-write strobes of an analog-to-digital converter, its reset and its entry into low-power stop. It decides when the conversion in progress, or a queued sequence of conversions, has to be thrown away. It also decides whether a fresh conversion is launched afterwards. The converter takes three single-cycle commands from it: `abort_o` cancels the running conversion, `flush_o` also discards every queued conversion, and `start_o` launches a new conversion or sequence.

Two fields set the behaviour. The first is the channel field `chan_sel`, where all ones means the converter is switched off. The second is the queue-depth field `fifo_depth`, where zero selects single-conversion operation and any other value selects queued operation with that many entries. In queued operation, each control write adds one channel entry and increments `fill_cnt`. The sequence starts only once the count reaches the programmed depth.

The controller is a Moore state machine with seven states:

| State | Outputs |
|---|---|
| `ST_RESET` | abort and flush |
| `ST_IDLE` | none |
| `ST_ABORT` | abort |
| `ST_ABORT_RESTART` | abort, start due next |
| `ST_FLUSH` | abort and flush |
| `ST_FLUSH_RESTART` | abort and flush, start due next |
| `ST_START` | start |

Transitions:

- A configuration write or an abort from stop entry moves to `ST_FLUSH` in queued operation and to `ST_ABORT` otherwise.
- A control write in single operation moves to `ST_ABORT_RESTART`, or to `ST_ABORT` when the channel is off.
- A control write in queued operation moves to `ST_FLUSH_RESTART` when it completes the fill, and to `ST_FLUSH` otherwise.
- With no event, `ST_ABORT_RESTART` and `ST_FLUSH_RESTART` move to `ST_START`.
- With no event, every other state moves to `ST_IDLE`.
- An event always overrides a pending start.

Top module: `adc_abort_ctrl`

## Requirements
- R1: While `rst_n` is low, `abort_o` and `flush_o` are 1, `start_o` is 0 and `fill_cnt` is 0. The first cycle after release with no event shows all three outputs at 0.
- R2: A control write with `fifo_depth` = 0 and `chan_sel` not all ones raises `abort_o` for one cycle after the sampling edge, and raises `start_o` for exactly the following cycle. `flush_o` stays 0.
- R3: A control write with `fifo_depth` = 0 and `chan_sel` all ones raises `abort_o` only. No start follows.
- R4: A control write with `fifo_depth` nonzero and `chan_sel` not all ones raises `abort_o` and `flush_o`. When `fill_cnt`+1 is below `fifo_depth`, the write increments `fill_cnt` and no start follows.
- R5: A control write in queued operation that brings `fill_cnt`+1 to `fifo_depth` or above raises `abort_o` and `flush_o`, clears `fill_cnt` to 0, and raises `start_o` in the following cycle.
- R6: A write on any bit of `cfg_wr` raises `abort_o`, raises `flush_o` when `fifo_depth` is nonzero, clears `fill_cnt` and launches no start. In the same cycle it overrides a control write.
- R7: A rising edge of `stop_req` while `async_clk_en` is 0 acts as a configuration write (as in R6). With `async_clk_en` at 1, or while `stop_req` stays high, it has no effect on any output.
- R8: A control write in queued operation with `chan_sel` all ones raises `abort_o` and `flush_o`, clears `fill_cnt` and launches no start.
- R9: Any event arriving in the cycle where a start is pending replaces that start with the event's own response.
- R10: In cycles without any event or pending start, all three command outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe of the primary control register |
| cfg_wr | input | NCFG | Write strobes of the secondary configuration and compare-value registers |
| chan_sel | input | CH_W | Channel field; all ones means converter off |
| fifo_depth | input | DEP_W | Queue depth; 0 selects single operation |
| stop_req | input | 1 | Stop-mode request level |
| async_clk_en | input | 1 | Converter runs from its own clock, so stop does not abort |
| abort_o | output | 1 | Abort the running conversion |
| start_o | output | 1 | Launch a conversion or sequence |
| flush_o | output | 1 | Discard queued conversions |
| fill_cnt | output | DEP_W | Channel entries collected toward the programmed depth |

## Verification
`abort_o`, `flush_o` and `fill_cnt` respond at the first rising edge that samples the stimulus. `start_o` follows one edge later, and only when no new event arrives in that cycle. The bench drives inputs on the falling edge and steps a reference model once per cycle, so each expectation matches the state after the next rising edge. All four outputs are compared at the following falling edge. Because of this, the one-cycle offset between abort and start is checked on every cycle, not inferred.

// File: rtl/adc_abort_pkg.sv
package adc_abort_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_IDLE,
        ST_ABORT,
        ST_ABORT_RESTART,
        ST_FLUSH,
        ST_FLUSH_RESTART,
        ST_START
    } abort_state_e;

    typedef struct packed {
        logic kill;       // configuration write or stop-entry abort
        logic ctl;        // control write
        logic fifo_mode;  // depth nonzero
        logic chan_off;   // channel field all ones
        logic cnt_clr;    // clear fill counter
        logic cnt_inc;    // count one channel entry
    } evt_t;

endpackage

// File: rtl/adc_abort_evt.sv
module adc_abort_evt
    import adc_abort_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int DEP_W = 3,
    parameter int NCFG  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [NCFG-1:0]  cfg_wr,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic [DEP_W-1:0] fifo_depth,
    input  logic             stop_req,
    input  logic             async_clk_en,
    output evt_t             evt
);

    logic stop_q;
    logic stop_abort;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= stop_req;
    end

    always_comb begin
        stop_abort    = stop_req && !stop_q && !async_clk_en;
        evt.kill      = (|cfg_wr) || stop_abort;
        evt.ctl       = ctl_wr;
        evt.fifo_mode = (fifo_depth != '0);
        evt.chan_off  = (&chan_sel);
        evt.cnt_clr   = evt.kill || (ctl_wr && evt.fifo_mode && evt.chan_off);
        evt.cnt_inc   = ctl_wr && evt.fifo_mode && !evt.chan_off && !evt.kill;
    end

    // R7: stop held high never produces a second kill by itself
    p_stop_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && stop_req && (cfg_wr == '0)) |-> !evt.kill);

endmodule

// File: rtl/adc_abort_fill.sv
module adc_abort_fill #(
    parameter int DEP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [DEP_W-1:0] depth,
    output logic [DEP_W-1:0] cnt,
    output logic             reach
);

    localparam int SUM_W = DEP_W + 1;

    logic [SUM_W-1:0] nxt;

    always_comb begin
        nxt   = {1'b0, cnt} + SUM_W'(1);
        reach = inc && (nxt >= {1'b0, depth});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (clr || reach) cnt <= '0;
        else if (inc)          cnt <= nxt[DEP_W-1:0];
    end

    // R4: the count only steps by one or returns to zero
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> ((cnt == '0) || (cnt == DEP_W'($past(cnt) + 1'b1))));

    // R6: a clear request empties the counter
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/adc_abort_fsm.sv
module adc_abort_fsm
    import adc_abort_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt,
    input  logic reach,
    output logic abort_o,
    output logic start_o,
    output logic flush_o
);

    abort_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = ST_IDLE;
        if (evt.kill) begin
            state_nxt = evt.fifo_mode ? ST_FLUSH : ST_ABORT;
        end else if (evt.ctl) begin
            if (evt.fifo_mode)     state_nxt = reach ? ST_FLUSH_RESTART : ST_FLUSH;
            else if (evt.chan_off) state_nxt = ST_ABORT;
            else                   state_nxt = ST_ABORT_RESTART;
        end else begin
            unique case (state)
                ST_ABORT_RESTART,
                ST_FLUSH_RESTART: state_nxt = ST_START;
                ST_RESET,
                ST_IDLE,
                ST_ABORT,
                ST_FLUSH,
                ST_START:         state_nxt = ST_IDLE;
                default:          state_nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        abort_o = 1'b0;
        start_o = 1'b0;
        flush_o = 1'b0;
        unique case (state)
            ST_RESET:         begin abort_o = 1'b1; flush_o = 1'b1; end
            ST_IDLE:          ;
            ST_ABORT:         abort_o = 1'b1;
            ST_ABORT_RESTART: abort_o = 1'b1;
            ST_FLUSH:         begin abort_o = 1'b1; flush_o = 1'b1; end
            ST_FLUSH_RESTART: begin abort_o = 1'b1; flush_o = 1'b1; end
            ST_START:         start_o = 1'b1;
            default:          ;
        endcase
    end

    // R2: a start is always preceded by an abort one cycle earlier
    p_start_after_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(abort_o));

    // R2: start lasts a single cycle
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R6: flushing always comes with an abort
    p_flush_has_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> abort_o);

endmodule

// File: rtl/adc_abort_ctrl.sv
module adc_abort_ctrl
    import adc_abort_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int DEP_W = 3,
    parameter int NCFG  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [NCFG-1:0]  cfg_wr,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic [DEP_W-1:0] fifo_depth,
    input  logic             stop_req,
    input  logic             async_clk_en,
    output logic             abort_o,
    output logic             start_o,
    output logic             flush_o,
    output logic [DEP_W-1:0] fill_cnt
);

    evt_t evt;
    logic reach;

    adc_abort_evt #(.CH_W(CH_W), .DEP_W(DEP_W), .NCFG(NCFG)) u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .cfg_wr       (cfg_wr),
        .chan_sel     (chan_sel),
        .fifo_depth   (fifo_depth),
        .stop_req     (stop_req),
        .async_clk_en (async_clk_en),
        .evt          (evt)
    );

    adc_abort_fill #(.DEP_W(DEP_W)) u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (evt.cnt_clr),
        .inc   (evt.cnt_inc),
        .depth (fifo_depth),
        .cnt   (fill_cnt),
        .reach (reach)
    );

    adc_abort_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .reach   (reach),
        .abort_o (abort_o),
        .start_o (start_o),
        .flush_o (flush_o)
    );

    // R6: configuration writes abort and never start
    p_cfg_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr != '0) |=> (abort_o && !start_o));

    // R7: stop entry with the converter's own clock running leaves outputs quiet
    p_stop_async_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && async_clk_en && !ctl_wr && (cfg_wr == '0)) |=> !abort_o);

    // R3: a disabled channel in single operation never starts
    p_off_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (cfg_wr == '0) && (&chan_sel) && (fifo_depth == '0)) |=> ##1 !start_o);

endmodule

// File: tb/adc_abort_ctrl_bench.sv
module adc_abort_ctrl_bench;

    localparam int CH_W  = 5;
    localparam int DEP_W = 3;
    localparam int NCFG  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [NCFG-1:0]  cfg_wr = '0;
    logic [CH_W-1:0]  chan_sel = '0;
    logic [DEP_W-1:0] fifo_depth = '0;
    logic             stop_req = 1'b0;
    logic             async_clk_en = 1'b0;
    logic             abort_o, start_o, flush_o;
    logic [DEP_W-1:0] fill_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    bit             m_abort, m_start, m_flush, m_pend, m_stop_prev;
    int             m_cnt;
    string          m_req;

    always #2 clk = ~clk;

    adc_abort_ctrl #(.CH_W(CH_W), .DEP_W(DEP_W), .NCFG(NCFG)) u_adc_abort_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .cfg_wr(cfg_wr),
        .chan_sel(chan_sel), .fifo_depth(fifo_depth), .stop_req(stop_req),
        .async_clk_en(async_clk_en), .abort_o(abort_o), .start_o(start_o),
        .flush_o(flush_o), .fill_cnt(fill_cnt)
    );

    function automatic void model_step();
        bit stop_ab = stop_req && !m_stop_prev && !async_clk_en;
        bit kill    = (cfg_wr != '0) || stop_ab;
        bit fifo    = (fifo_depth != 0);
        bit off     = (&chan_sel);
        m_stop_prev = stop_req;
        m_start = 0; m_abort = 0; m_flush = 0;
        if (kill) begin
            m_abort = 1; m_flush = fifo; m_cnt = 0; m_pend = 0;
            m_req = stop_ab ? "R7" : "R6";
        end else if (ctl_wr) begin
            m_abort = 1;
            if (fifo) begin
                m_flush = 1;
                if (off) begin m_cnt = 0; m_pend = 0; m_req = "R8"; end
                else if (m_cnt + 1 >= int'(fifo_depth)) begin
                    m_cnt = 0; m_pend = 1; m_req = "R5";
                end else begin m_cnt = m_cnt + 1; m_pend = 0; m_req = "R4"; end
            end else begin
                m_pend = !off; m_req = off ? "R3" : "R2";
            end
        end else begin
            m_start = m_pend;
            m_req   = m_pend ? "R2" : "R10";
            m_pend  = 0;
        end
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        check(m_req, "abort_o", int'(abort_o), int'(m_abort));
        check(m_req, "start_o", int'(start_o), int'(m_start));
        check(m_req, "flush_o", int'(flush_o), int'(m_flush));
        check(m_req, "fill_cnt", int'(fill_cnt), m_cnt);
    endtask

    // one cycle: compare previous expectations, apply new stimulus, predict
    task automatic cycle(input bit c, input logic [NCFG-1:0] g, input logic [CH_W-1:0] ch,
                         input logic [DEP_W-1:0] d, input bit s, input bit a);
        @(negedge clk);
        check_outputs();
        ctl_wr = c; cfg_wr = g; chan_sel = ch; fifo_depth = d;
        stop_req = s; async_clk_en = a;
        model_step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, '0, chan_sel, fifo_depth, stop_req, async_clk_en);
    endtask

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1", "abort_o", int'(abort_o), 1);
        check("R1", "flush_o", int'(flush_o), 1);
        check("R1", "start_o", int'(start_o), 0);
        check("R1", "fill_cnt", int'(fill_cnt), 0);
        rst_n = 1'b1;
        m_abort = 0; m_start = 0; m_flush = 0; m_pend = 0; m_cnt = 0;
        m_stop_prev = 0; m_req = "R1";
        model_step();
        m_req = "R1";

        // R2: single restart
        cycle(1, '0, 5'd3, 3'd0, 0, 0);
        idle(3);
        // R3: channel off
        cycle(1, '0, 5'h1f, 3'd0, 0, 0);
        idle(3);
        // R4/R5: queued fill to depth 3
        cycle(1, '0, 5'd1, 3'd3, 0, 0);
        cycle(1, '0, 5'd2, 3'd3, 0, 0);
        idle(1);
        cycle(1, '0, 5'd4, 3'd3, 0, 0);
        idle(3);
        // R6: configuration write mid-fill, in queued and single operation
        cycle(1, '0, 5'd1, 3'd3, 0, 0);
        cycle(0, 5'b00100, 5'd1, 3'd3, 0, 0);
        idle(2);
        cycle(1, 5'b00001, 5'd1, 3'd0, 0, 0);
        idle(3);
        // R8: channel off in queued operation
        cycle(1, '0, 5'd1, 3'd2, 0, 0);
        cycle(1, '0, 5'h1f, 3'd2, 0, 0);
        idle(2);
        // R7: stop with own clock, then without, then held
        cycle(0, '0, 5'd1, 3'd0, 1, 1);
        idle(2);
        cycle(0, '0, 5'd1, 3'd0, 0, 0);
        cycle(0, '0, 5'd1, 3'd0, 1, 0);
        idle(4);
        cycle(0, '0, 5'd1, 3'd0, 0, 0);
        // R9: event during pending start
        cycle(1, '0, 5'd2, 3'd0, 0, 0);
        cycle(1, '0, 5'h1f, 3'd0, 0, 0);
        idle(3);
        cycle(1, '0, 5'd2, 3'd0, 0, 0);
        cycle(0, 5'b10000, 5'd2, 3'd0, 0, 0);
        idle(3);

        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            bit c = ($urandom % 100) < 35;
            logic [NCFG-1:0] g = (($urandom % 100) < 8) ? NCFG'(1 << ($urandom % NCFG)) : '0;
            logic [CH_W-1:0] ch = (($urandom % 100) < 15) ? '1 : CH_W'($urandom);
            logic [DEP_W-1:0] d = (i % 300 < 150) ? DEP_W'(0) : DEP_W'(1 + (i / 300) % 7);
            bit s = (($urandom % 100) < 20) ? ~stop_req : stop_req;
            bit a = (($urandom % 100) < 10) ? ~async_clk_en : async_clk_en;
            cycle(c, g, ch, d, s, a);
        end
        idle(3);
        @(negedge clk);
        check_outputs();

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule